// File: doc/BRIEF.md
# Sixteen-Bit Multiplexer-Shaped ALU

This block is a registered 16-bit arithmetic-logic unit for a small accumulator-style datapath. There is no dedicated logic-function unit. For every bit, two small four-input lookup multiplexers, indexed by the operand bits, produce the two operands of one binary adder. The chosen function code sets the contents of those lookup tables and the adder's carry input.

The adder is split into four identical 4-bit slices, and the carry ripples from each slice to the next. Because of this, a 16-bit add with carry is the slowest path through the block. The block supports eight operations: add, subtract, AND, OR, XOR, invert, shift left and shift right. The result and the carry output are captured on the rising clock edge, so a result can be read one cycle after its operands and function code are presented.

Top module: `mux_alu16`

## Requirements
- R1: While `rst` is high at a rising edge, `q` is cleared to 0 and `cout` to 0 at that edge.
- R2: Function code 0 (add) gives `q` equal to the low 16 bits of a+b+cin and `cout` equal to bit 16 of that sum.
- R3: Function code 1 (subtract) gives `q` equal to a-b modulo 2^16. Here `cout` is 1 exactly when a >= b, and `cin` has no effect.
- R4: Function codes 2, 3 and 4 give `q` equal to a AND b, a OR b and a XOR b, with `cout` cleared.
- R5: Function code 5 (invert) gives `q` equal to the bitwise complement of a, with `cout` cleared.
- R6: Function code 6 (shift left) gives `q` equal to a shifted left one place with 0 entering bit 0, and `cout` equal to a[15].
- R7: Function code 7 (shift right) gives `q` equal to a shifted right one place with 0 entering bit 15, and `cout` equal to a[0].
- R8: Every function code from 8 to 31 gives `q` equal to a and clears `cout`.
- R9: A carry produced in bit 0 ripples through all four 4-bit slices. For example, add of 0xFFFF and 0x0000 with cin=1 gives `q`=0 and `cout`=1.
- R10: Outputs change only at a rising edge and reflect the inputs present at that edge; `q` and `cout` keep their values between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| fn | input | 5 | Function code |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry input, used by add only |
| q | output | 16 | Registered result |
| cout | output | 1 | Registered carry output |

## Verification
The bound checker compares the registered result with the inputs of the previous cycle on every cycle, for each of the following:
- add with its full 17-bit sum;
- the borrow sense of subtract;
- invert;
- the shift-left and shift-right carry bits;
- the pass-through of unused codes;
- the cleared state just after reset.

Only the bench scenarios show some behaviours: the logic functions, the slice-to-slice ripple on carefully chosen operands such as all-ones plus a carry, and the fact that `cin` has no effect on subtract. The bench also checks that results arrive exactly one edge after their operands and stay unchanged between edges.

// File: rtl/mux_alu16.sv
module mux_alu16 #(
  parameter int WIDTH = 16,
  parameter int SLICE = 4,
  parameter int FNW   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FNW-1:0]   fn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] q,
  output logic             cout
);
  localparam int NSLICE = WIDTH / SLICE;
  localparam logic [FNW-1:0] FN_ADD = FNW'(0);
  localparam logic [FNW-1:0] FN_SUB = FNW'(1);
  localparam logic [FNW-1:0] FN_AND = FNW'(2);
  localparam logic [FNW-1:0] FN_OR  = FNW'(3);
  localparam logic [FNW-1:0] FN_XOR = FNW'(4);
  localparam logic [FNW-1:0] FN_INV = FNW'(5);
  localparam logic [FNW-1:0] FN_SHL = FNW'(6);
  localparam logic [FNW-1:0] FN_SHR = FNW'(7);

  // Lookup tables indexed by {a_bit, b_bit}: entry 3 = 11, 2 = 10, 1 = 01, 0 = 00
  logic [3:0] xtab, ytab;
  logic       c0;

  always_comb begin
    xtab = 4'b1100;
    ytab = 4'b0000;
    c0   = 1'b0;
    case (fn)
      FN_ADD: begin ytab = 4'b1010; c0 = cin;  end
      FN_SUB: begin ytab = 4'b0101; c0 = 1'b1; end
      FN_AND: xtab = 4'b1000;
      FN_OR:  xtab = 4'b1110;
      FN_XOR: xtab = 4'b0110;
      FN_INV: xtab = 4'b0011;
      FN_SHL: ytab = 4'b1100;
      FN_SHR: xtab = 4'b1100;
      default: ;
    endcase
  end

  logic [WIDTH-1:0]  asrc, x, y, sum;
  logic [NSLICE:0]   c;

  assign asrc = (fn == FN_SHR) ? {1'b0, a[WIDTH-1:1]} : a;
  assign c[0] = c0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign x[i] = xtab[{asrc[i], b[i]}];
    assign y[i] = ytab[{asrc[i], b[i]}];
  end

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    assign {c[s+1], sum[s*SLICE +: SLICE]} =
        {1'b0, x[s*SLICE +: SLICE]} + {1'b0, y[s*SLICE +: SLICE]} + {{SLICE{1'b0}}, c[s]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      cout <= 1'b0;
    end else begin
      q    <= sum;
      cout <= (fn == FN_SHR) ? a[0] : c[NSLICE];
    end
  end
endmodule

// File: rtl/mux_alu16_chk.sv
module mux_alu16_chk #(
  parameter int WIDTH = 16,
  parameter int FNW   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [FNW-1:0]   fn,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] q,
  input logic             cout
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (q == '0 && !cout));

  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (fn == FNW'(0)) |=> ({cout, q} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{WIDTH{1'b0}}, $past(cin)})));

  // R3
  sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (fn == FNW'(1)) |=> (cout == ($past(a) >= $past(b)) && q == $past(a) - $past(b)));

  // R5
  inv_chk: assert property (@(posedge clk) disable iff (rst)
    (fn == FNW'(5)) |=> (q == ~$past(a) && !cout));

  // R6
  shl_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (fn == FNW'(6)) |=> (cout == $past(a[WIDTH-1]) && q[0] == 1'b0));

  // R7
  shr_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (fn == FNW'(7)) |=> (cout == $past(a[0]) && q[WIDTH-1] == 1'b0));

  // R8
  unused_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (fn >= FNW'(8)) |=> (q == $past(a) && !cout));
endmodule

bind mux_alu16 mux_alu16_chk #(.WIDTH(WIDTH), .FNW(FNW)) u_chk (
  .clk(clk), .rst(rst), .fn(fn), .a(a), .b(b), .cin(cin), .q(q), .cout(cout));

// File: tb/mux_alu16_bench.sv
module mux_alu16_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  fn  = '0;
  logic [15:0] a   = '0;
  logic [15:0] b   = '0;
  logic        cin = 1'b0;
  logic [15:0] q;
  logic        cout;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int          due;
    logic [15:0] q;
    logic        c;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mux_alu16 u_mux_alu16 (.clk(clk), .rst(rst), .fn(fn), .a(a), .b(b), .cin(cin), .q(q), .cout(cout));

  function automatic logic [16:0] model(input logic [4:0] f, input logic [15:0] x,
                                        input logic [15:0] y, input logic ci);
    case (f)
      5'd0: return {1'b0, x} + {1'b0, y} + {16'd0, ci};
      5'd1: return {(x >= y), 16'(x - y)};
      5'd2: return {1'b0, x & y};
      5'd3: return {1'b0, x | y};
      5'd4: return {1'b0, x ^ y};
      5'd5: return {1'b0, ~x};
      5'd6: return {x[15], x[14:0], 1'b0};
      5'd7: return {x[0], 1'b0, x[15:1]};
      default: return {1'b0, x};
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] gq, input logic gc,
                       input logic [15:0] eq, input logic ec);
    checks++;
    if (gq !== eq || gc !== ec) begin
      errors++;
      $display("FAIL %s q=%h cout=%b expected q=%h cout=%b", tag, gq, gc, eq, ec);
    end
  endtask

  task automatic drive(input string tag, input logic [4:0] f, input logic [15:0] x,
                       input logic [15:0] y, input logic ci);
    logic [16:0] e;
    @(negedge clk);
    fn = f; a = x; b = y; cin = ci;
    e = model(f, x, y, ci);
    sb.push_back('{cyc + 1, e[15:0], e[16], tag});
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      check(it.tag, q, cout, it.q, it.c);
    end
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r1, r2;
    repeat (3) @(negedge clk);
    check("R1 reset", q, cout, 16'h0000, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    drive("R2 add", 5'd0, 16'h1234, 16'h4321, 1'b0);
    drive("R2 add cin", 5'd0, 16'h8000, 16'h8000, 1'b1);
    drive("R9 ripple", 5'd0, 16'hFFFF, 16'h0000, 1'b1);
    drive("R9 ripple b", 5'd0, 16'h0FFF, 16'h0001, 1'b0);
    drive("R3 sub", 5'd1, 16'h0005, 16'h0003, 1'b0);
    drive("R3 sub cin", 5'd1, 16'h0005, 16'h0003, 1'b1);
    drive("R3 borrow", 5'd1, 16'h0003, 16'h0005, 1'b1);
    drive("R3 equal", 5'd1, 16'hA5A5, 16'hA5A5, 1'b0);
    drive("R4 and", 5'd2, 16'hF0F0, 16'hFF00, 1'b1);
    drive("R4 or", 5'd3, 16'hF0F0, 16'h0F00, 1'b1);
    drive("R4 xor", 5'd4, 16'hFFFF, 16'h1234, 1'b1);
    drive("R5 inv", 5'd5, 16'h00FF, 16'hFFFF, 1'b1);
    drive("R6 shl", 5'd6, 16'h8001, 16'hFFFF, 1'b1);
    drive("R7 shr", 5'd7, 16'h8001, 16'hFFFF, 1'b1);
    drive("R7 shr zero", 5'd7, 16'h0002, 16'h0000, 1'b0);
    drive("R8 unused 8", 5'd8, 16'hBEEF, 16'hFFFF, 1'b1);
    drive("R8 unused 31", 5'd31, 16'hFFFF, 16'hFFFF, 1'b1);
    r1 = 16'h1ACE; r2 = 16'h7B31;
    for (int i = 0; i < 400; i++) begin
      r1 = r1 * 16'd25173 + 16'd13849;
      r2 = r2 * 16'd40503 + 16'd2731;
      drive("R10 mixed", 5'(i % 32), r1, r2, r2[3]);
    end
    @(negedge clk);
    @(negedge clk);
    // R10: hold value between edges, no change away from the clock
    r1 = q;
    #2;
    check("R10 hold", q, cout, r1, cout);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", q, cout, 16'h0000, 1'b0);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10 %0d results never compared, expected 0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule